// File: doc/BRIEF.md
# PLL Reconfiguration Command Sequencer

This block reprograms an integer-mode I/O PLL through a memory-mapped management port. A range code gives the pixel-clock band and a 2-bit code gives the output colour depth. From these two codes the block computes a set of divider, charge-pump and loop-filter settings. It sends them to the PLL as a burst of single-cycle writes, then writes the start register. It waits on the PLL's busy line and finally raises a done flag, which stays high until it is acknowledged.

The request is a level. The codes are captured on the cycle the sequence is accepted. The request can be withdrawn while the settings are still being written, and the block then goes back to idle without starting the PLL. Once the start write has gone out, the block follows the busy handshake through to completion. The busy line belongs to another clock domain, so it is resynchronized inside the block.

Top module: `pll_reconfig_seq`

## Requirements
- R1: After reset `mgmt_write_o` and `done_o` are low, and no write is emitted until `req_i` is seen high.
- R2: An accepted request produces writes on consecutive cycles, each with the strobe high for one cycle. The addresses are 0x090 (feedback M), 0x0A0 (N), 0x0C0, 0x0C1, 0x0C2 (output counters 0, 1, 2), 0x020 (charge pump) and 0x040 (loop filter), in that order. A start write to address 0x000 with data 1 follows, and then the strobe goes low.
- R3: At most eight setting writes are issued before a start write.
- R4: A divider word carries zeros in bits 31:16. Bits 15:8 hold ceil(v/2) and bits 7:0 hold floor(v/2) for divide value v, so 75 gives 0x00002625 and 5 gives 0x00000302. N is always 1 and is written as the bypass word 0x00010000.
- R5: Range code 0 selects M=30, C0=6, C1=60, CP=0x10, BW=0x100. Code 1 selects M=20, C0=4, C1=40, CP=0x0B, BW=0xC0. Code 2 selects M=10, C0=2, C1=20. Code 3 selects M=8, C0=8, C1=16. Code 4 selects M=8, C0=4, C1=8. Code 5 and every other code select M=8, C0=2, C1=4. Codes other than 0 and 1 use CP=0x10 and BW=0xC0.
- R6: Output counter 2 is C1 scaled by the depth code. Code 0 scales by 1, code 1 by 1.25, code 2 by 1.5 and code 3 by 2.
- R7: After the start write the block waits for the synchronized busy line to rise before it waits for it to fall. If busy never rises, done never asserts.
- R8: `done_o` rises on the third rising clock edge after `busy_i` falls. It stays high while `ack_i` is low and goes low on the edge that samples `ack_i` high.
- R9: The range and depth codes are captured when the request is accepted. Later changes to them, and the level of `req_i` after the start write, have no effect on the sequence.
- R10: If `req_i` is low while setting writes are in progress, the block finishes the write of that cycle and then returns to idle. It issues no start write and does not assert done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Reconfiguration request, level |
| range_i | input | 3 | Pixel-clock range code |
| depth_i | input | 2 | Colour depth code (8/10/12/16 bits) |
| ack_i | input | 1 | Clears done |
| busy_i | input | 1 | PLL busy / waitrequest, asynchronous |
| mgmt_write_o | output | 1 | Management write strobe |
| mgmt_addr_o | output | 9 | Management write address |
| mgmt_wdata_o | output | 32 | Management write data |
| done_o | output | 1 | Reconfiguration complete |

## Verification
The assertions assume three things about the inputs. The PLL raises busy only after the start write, and drops it at some later point. `ack_i` is given only while done is high. `req_i` is low again before the acknowledge, so a finished sequence does not restart at once. The stimulus keeps to these by acting as the PLL: it raises busy a chosen number of cycles after the start write, including a long delay, holds it for several cycles and then releases it. It always drops the request before it pulses the acknowledge. The abort case withdraws the request while setting writes are still in flight.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int ADDR_W  = 9;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = 8;
  localparam int DIV_W   = HALF_W + 1;
  localparam int DEPTH_W = 2;
  localparam int NUM_DIV = 5;             // M, N, C0, C1, C2
  localparam int NUM_CMD = NUM_DIV + 2;   // plus CP, BW
  localparam int MAX_CMD = 8;             // PLL command buffer depth
  localparam int IDX_W   = $clog2(NUM_CMD);

  localparam logic [DATA_W-1:0] START_WORD = DATA_W'(1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_START,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [DIV_W-1:0]  m;
    logic [DIV_W-1:0]  c0;
    logic [DIV_W-1:0]  c1;
    logic [DATA_W-1:0] cp;
    logic [DATA_W-1:0] bw;
  } range_cfg_t;

  // command slot -> register address; order is the write order
  function automatic logic [ADDR_W-1:0] slot_addr(input int unsigned slot);
    case (slot)
      0:       return ADDR_W'(9'h090);
      1:       return ADDR_W'(9'h0A0);
      2:       return ADDR_W'(9'h0C0);
      3:       return ADDR_W'(9'h0C1);
      4:       return ADDR_W'(9'h0C2);
      5:       return ADDR_W'(9'h020);
      default: return ADDR_W'(9'h040);
    endcase
  endfunction

  function automatic range_cfg_t range_cfg(input int unsigned code);
    range_cfg_t c;
    c.cp = DATA_W'(32'h10);
    c.bw = DATA_W'(32'hC0);
    case (code)
      0: begin
        c.m = DIV_W'(30); c.c0 = DIV_W'(6); c.c1 = DIV_W'(60);
        c.bw = DATA_W'(32'h100);
      end
      1: begin
        c.m = DIV_W'(20); c.c0 = DIV_W'(4); c.c1 = DIV_W'(40);
        c.cp = DATA_W'(32'h0B);
      end
      2: begin c.m = DIV_W'(10); c.c0 = DIV_W'(2); c.c1 = DIV_W'(20); end
      3: begin c.m = DIV_W'(8);  c.c0 = DIV_W'(8); c.c1 = DIV_W'(16); end
      4: begin c.m = DIV_W'(8);  c.c0 = DIV_W'(4); c.c1 = DIV_W'(8);  end
      default: begin c.m = DIV_W'(8); c.c0 = DIV_W'(2); c.c1 = DIV_W'(4); end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pllseq_div_enc.sv
module pllseq_div_enc
  import pllseq_pkg::*;
(
  input  logic [DIV_W-1:0]  div_i,
  output logic [DATA_W-1:0] word_o
);

  logic [HALF_W-1:0] hi_cnt;
  logic [HALF_W-1:0] lo_cnt;

  // odd divide: high phase takes the extra cycle
  assign hi_cnt = HALF_W'(({1'b0, div_i} + 1'b1) >> 1);
  assign lo_cnt = HALF_W'(div_i >> 1);

  always_comb begin
    if (div_i == DIV_W'(1)) word_o = DATA_W'(32'h0001_0000);  // bypass
    else                    word_o = DATA_W'({hi_cnt, lo_cnt});
  end

endmodule

// File: rtl/pllseq_table.sv
module pllseq_table
  import pllseq_pkg::*;
#(
  parameter int RANGE_W = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             capture_i,
  input  logic [RANGE_W-1:0]               range_i,
  input  logic [DEPTH_W-1:0]               depth_i,
  output logic [NUM_CMD-1:0][ADDR_W-1:0]   cmd_addr_o,
  output logic [NUM_CMD-1:0][DATA_W-1:0]   cmd_data_o
);

  logic [RANGE_W-1:0]            range_q;
  logic [DEPTH_W-1:0]            depth_q;
  range_cfg_t                    cfg;
  logic [DIV_W-1:0]              c2;
  logic [NUM_DIV-1:0][DIV_W-1:0] div_val;
  logic [NUM_DIV-1:0][DATA_W-1:0] div_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q <= '0;
      depth_q <= '0;
    end else if (capture_i) begin
      range_q <= range_i;
      depth_q <= depth_i;
    end
  end

  assign cfg = range_cfg(int'(range_q));

  always_comb begin
    case (depth_q)
      2'd0:    c2 = cfg.c1;
      2'd1:    c2 = DIV_W'(cfg.c1 + (cfg.c1 >> 2));
      2'd2:    c2 = DIV_W'(cfg.c1 + (cfg.c1 >> 1));
      default: c2 = DIV_W'(cfg.c1 << 1);
    endcase
  end

  assign div_val[0] = cfg.m;
  assign div_val[1] = DIV_W'(1);
  assign div_val[2] = cfg.c0;
  assign div_val[3] = cfg.c1;
  assign div_val[4] = c2;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_enc
    pllseq_div_enc u_enc (
      .div_i  (div_val[g]),
      .word_o (div_word[g])
    );
  end

  for (genvar s = 0; s < NUM_CMD; s++) begin : g_slot
    assign cmd_addr_o[s] = slot_addr(s);
    if (s < NUM_DIV) begin : g_div
      assign cmd_data_o[s] = div_word[s];
    end else if (s == NUM_DIV) begin : g_cp
      assign cmd_data_o[s] = cfg.cp;
    end else begin : g_bw
      assign cmd_data_o[s] = cfg.bw;
    end
  end

  AST_C2_SCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2 >= cfg.c1) && (c2 <= DIV_W'(cfg.c1 << 1)));  // R6

endmodule

// File: rtl/pllseq_sync.sv
module pllseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           ack_i,
  input  logic                           busy_sync_i,
  input  logic [NUM_CMD-1:0][ADDR_W-1:0] cmd_addr_i,
  input  logic [NUM_CMD-1:0][DATA_W-1:0] cmd_data_i,
  output logic                           capture_o,
  output logic                           wr_o,
  output logic [ADDR_W-1:0]              addr_o,
  output logic [DATA_W-1:0]              data_o,
  output logic                           done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CMD - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_CMD;
        idx_d   = '0;
      end
      ST_CMD: begin
        if (!req_i)                state_d = ST_IDLE;  // abort, no start
        else if (idx_q == LAST_IDX) state_d = ST_START;
        else                        idx_d   = idx_q + 1'b1;
      end
      ST_START:   state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (busy_sync_i)  state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (!busy_sync_i) state_d = ST_DONE;
      ST_DONE:    if (ack_i)        state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign capture_o = (state_q == ST_IDLE) && req_i;
  assign wr_o      = (state_q == ST_CMD) || (state_q == ST_START);
  assign done_o    = (state_q == ST_DONE);

  always_comb begin
    addr_o = '0;
    data_o = '0;
    if (state_q == ST_CMD) begin
      addr_o = cmd_addr_i[idx_q];
      data_o = cmd_data_i[idx_q];
    end else if (state_q == ST_START) begin
      data_o = START_WORD;
    end
  end

  // setting writes since the last idle, for the overflow check
  logic [3:0] ast_wr_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ast_wr_cnt <= '0;
    else if (state_q == ST_IDLE)               ast_wr_cnt <= '0;
    else if (wr_o && addr_o != '0 && ast_wr_cnt != 4'hF)
      ast_wr_cnt <= ast_wr_cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ast_wr_cnt <= 4'(MAX_CMD));  // R3
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && addr_o == '0) |=> !wr_o);  // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> done_o);  // R8
  AST_DONE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(busy_sync_i));  // R7
  AST_ABORT_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && addr_o != '0 && !req_i) |=> !wr_o);  // R10

endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pllseq_pkg::*;
#(
  parameter int RANGE_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               ack_i,
  input  logic               busy_i,
  output logic               mgmt_write_o,
  output logic [ADDR_W-1:0]  mgmt_addr_o,
  output logic [DATA_W-1:0]  mgmt_wdata_o,
  output logic               done_o
);

  logic                           capture;
  logic                           busy_sync;
  logic [NUM_CMD-1:0][ADDR_W-1:0] cmd_addr;
  logic [NUM_CMD-1:0][DATA_W-1:0] cmd_data;

  pllseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (busy_i),
    .q_o    (busy_sync)
  );

  pllseq_table #(.RANGE_W(RANGE_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .range_i    (range_i),
    .depth_i    (depth_i),
    .cmd_addr_o (cmd_addr),
    .cmd_data_o (cmd_data)
  );

  pllseq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .ack_i       (ack_i),
    .busy_sync_i (busy_sync),
    .cmd_addr_i  (cmd_addr),
    .cmd_data_i  (cmd_data),
    .capture_o   (capture),
    .wr_o        (mgmt_write_o),
    .addr_o      (mgmt_addr_o),
    .data_o      (mgmt_wdata_o),
    .done_o      (done_o)
  );

endmodule

// File: tb/tb_pll_reconfig_seq.sv
module tb_pll_reconfig_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  range_c = '0;
  logic [1:0]  depth_c = '0;
  logic        ack = 1'b0;
  logic        busy = 1'b0;
  logic        wr;
  logic [8:0]  addr;
  logic [31:0] wdata;
  logic        done;

  always #4 clk = ~clk;  // 125 MHz

  pll_reconfig_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .range_i(range_c),
    .depth_i(depth_c), .ack_i(ack), .busy_i(busy),
    .mgmt_write_o(wr), .mgmt_addr_o(addr), .mgmt_wdata_o(wdata),
    .done_o(done)
  );

  typedef struct {
    logic [8:0]  a;
    logic [31:0] d;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // divider word per R4
  function automatic logic [31:0] dw(input int v);
    if (v == 1) return 32'h0001_0000;
    return 32'((((v + 1) / 2) % 256) * 256 + ((v / 2) % 256));
  endfunction

  task automatic push_seq(input int r, input int d, input int n);
    int m, c0, c1, c2;
    logic [31:0] cp, bw;
    item_t lst[8];
    cp = 32'h10; bw = 32'hC0;
    case (r)  // R5
      0: begin m = 30; c0 = 6; c1 = 60; bw = 32'h100; end
      1: begin m = 20; c0 = 4; c1 = 40; cp = 32'h0B; end
      2: begin m = 10; c0 = 2; c1 = 20; end
      3: begin m = 8;  c0 = 8; c1 = 16; end
      4: begin m = 8;  c0 = 4; c1 = 8;  end
      default: begin m = 8; c0 = 2; c1 = 4; end
    endcase
    case (d)  // R6
      0: c2 = c1;
      1: c2 = c1 * 5 / 4;
      2: c2 = c1 * 3 / 2;
      default: c2 = c1 * 2;
    endcase
    lst[0] = '{9'h090, dw(m),  "R5"};
    lst[1] = '{9'h0A0, dw(1),  "R4"};
    lst[2] = '{9'h0C0, dw(c0), "R5"};
    lst[3] = '{9'h0C1, dw(c1), "R5"};
    lst[4] = '{9'h0C2, dw(c2), "R6"};
    lst[5] = '{9'h020, cp,     "R5"};
    lst[6] = '{9'h040, bw,     "R5"};
    lst[7] = '{9'h000, 32'h1,  "R2"};
    for (int i = 0; i < n; i++) q.push_back(lst[i]);
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && wr) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3", "unexpected write addr", 32'(addr), 32'hFFFF_FFFF);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(addr == e.a, e.tag, "write address", 32'(addr), 32'(e.a));
        chk(wdata == e.d, e.tag, "write data", wdata, e.d);
      end
    end
  end

  task automatic handshake(input int lag, input int hold);
    for (int i = 0; i < lag; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R7", "done before busy rose", 32'(done), 0);
    end
    busy = 1'b1;
    repeat (hold) @(negedge clk);
    chk(done == 1'b0, "R7", "done while busy", 32'(done), 0);
    busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done two edges after fall", 32'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R8", "done three edges after fall", 32'(done), 1);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8", "done held without ack", 32'(done), 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(done == 1'b0, "R8", "done after ack", 32'(done), 0);
  endtask

  task automatic run(input int r, input int d, input int lag, input bit mid_change);
    push_seq(r, d, 8);
    range_c = 3'(r);
    depth_c = 2'(d);
    req = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (mid_change && i == 1) begin  // R9
        range_c = ~range_c;
        depth_c = ~depth_c;
      end
    end
    chk(q.size() == 0, "R2", "items left after burst", 32'(q.size()), 0);
    chk(wr == 1'b0, "R2", "strobe after start write", 32'(wr), 0);
    handshake(lag, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    finish_test();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr == 1'b0, "R1", "write in reset", 32'(wr), 0);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(wr == 1'b0 && done == 1'b0, "R1", "idle after reset", 32'({wr, done}), 0);

    run(0, 0, 2, 1'b0);
    run(0, 1, 2, 1'b0);   // odd 75 -> 0x2625 (R4)
    run(1, 1, 3, 1'b0);
    run(2, 2, 1, 1'b0);
    run(3, 3, 2, 1'b0);
    run(4, 1, 2, 1'b0);
    run(5, 1, 2, 1'b0);   // 5 -> 0x0302 (R4)
    run(7, 2, 2, 1'b0);   // default range (R5)
    run(6, 3, 12, 1'b0);  // late busy (R7)
    run(2, 1, 2, 1'b1);   // codes change mid-sequence (R9)

    // R10: withdraw request during setting writes
    push_seq(3, 0, 2);
    range_c = 3'd3;
    depth_c = 2'd0;
    req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R10", "writes before abort", 32'(q.size()), 0);
    chk(wr == 1'b0, "R10", "strobe after abort", 32'(wr), 0);
    chk(done == 1'b0, "R10", "done after abort", 32'(done), 0);

    run(1, 0, 2, 1'b0);   // recovers after abort
    repeat (5) @(negedge clk);
    finish_test();
  end

endmodule